// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block is a small bank of eight 32-bit registers. A processor core reads and writes it with register-transfer coprocessor instructions. The register number sits in a four-bit field at instruction bits 19:16. Only the low three bits of that field are used, so bit 19 has no effect. A second port gives a debugger direct indexed access to the same registers.

Two entries are special:
- **Entry 0** is a fixed identification word. Writes to it are dropped.
- **Entry 1** is the control register. Its bits 7:4 drive four configuration outputs to the core: program-space width, data-space width, abort timing and endianness. Any write to entry 1 also raises a one-cycle request telling the core to re-evaluate its mode.

While reset is held, the four control bits load from strap inputs. The other entries reset to zero and act as plain storage. Both ports return read data one cycle after the request. A read returns the contents before any write accepted in the same cycle.

Top module: `scpbank_top`

## Requirements
- R1: While rstN is low (synchronous reset), entry 1 loads {24'b0, strapBigEnd, strapLateAbort, strapDataWide, strapProgWide, 4'b0}. Entries 2 to 7 clear to zero, reconfigPulse is low, and both read-data outputs are zero.
- R2: A read of entry 0 from either port returns 32'h41440110. Writes to entry 0 are ignored.
- R3: A core transfer selects entry xferInstr[18:16]; bit 19 is ignored. When xferValid is high and xferWrite is low, xferRdata shows that entry on the next cycle, with the value it held before the edge. xferRdata holds its value otherwise.
- R4: cfgProgWide, cfgDataWide, cfgLateAbort and cfgBigEnd equal entry 1 bits 4, 5, 6 and 7. They change in the cycle after an accepted write to entry 1, and at no other time outside reset.
- R5: Each accepted write to entry 1, from either port, makes reconfigPulse high for exactly the next cycle. Writes on back-to-back cycles give back-to-back pulses.
- R6: Entry 1 bits 31:8 and 3:0 are stored and read back, but they drive no output.
- R7: The debug port accepts dbgIndex 0 to 7. A write with dbgIndex 8 to 15 changes nothing and raises no pulse. A read with dbgIndex 8 to 15 returns zero on dbgRdata the next cycle.
- R8: Entries 2 to 7 hold the last value written from either port.
- R9: When a core write and a debug write occur in the same cycle, only the core write takes effect and the debug write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapProgWide | input | 1 | Reset value of control bit 4 |
| strapDataWide | input | 1 | Reset value of control bit 5 |
| strapLateAbort | input | 1 | Reset value of control bit 6 |
| strapBigEnd | input | 1 | Reset value of control bit 7 |
| xferValid | input | 1 | Core transfer request |
| xferWrite | input | 1 | Transfer direction: 1 = write to the bank, 0 = read |
| xferInstr | input | 32 | Instruction word; bits 18:16 select the entry |
| xferWdata | input | 32 | Core write data |
| xferRdata | output | 32 | Core read data, one cycle after the request |
| dbgValid | input | 1 | Debug access request |
| dbgWrite | input | 1 | Debug direction: 1 = write, 0 = read |
| dbgIndex | input | 4 | Debug entry index; 8 to 15 are out of range |
| dbgWdata | input | 32 | Debug write data |
| dbgRdata | output | 32 | Debug read data, one cycle after the request |
| cfgProgWide | output | 1 | Program-space width select (entry 1 bit 4) |
| cfgDataWide | output | 1 | Data-space width select (entry 1 bit 5) |
| cfgLateAbort | output | 1 | Late abort timing select (entry 1 bit 6) |
| cfgBigEnd | output | 1 | Endianness select (entry 1 bit 7) |
| reconfigPulse | output | 1 | One-cycle mode re-evaluation request |

## Verification
Every result of this bank is due exactly one clock edge after the request:
- read data on both ports,
- the four configuration outputs,
- the reconfigure pulse.

The bench model updates at the same posedge the design registers on. Inputs change only at negedges, and all outputs are compared against the model at the following negedge. A result that arrives a cycle early or late therefore mismatches directly. Directed debug read-backs then confirm that stored values persist and that ignored writes left no trace.

// File: rtl/scpbank_pkg.sv
package scpbank_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int FIELD_W   = 4;
  localparam int FIELD_LSB = 16;
  localparam int CFG_W     = 4;
  localparam int CFG_LSB   = 4;
  localparam int ID_IDX    = 0;
  localparam int CTRL_IDX  = 1;
  localparam logic [DATA_W-1:0] ID_VALUE = 32'h41440110;

  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [DATA_W-1:0] wrData;
    logic              coreRd;
    logic [IDX_W-1:0]  coreRdIdx;
    logic              dbgRd;
    logic              dbgRdOk;
    logic [IDX_W-1:0]  dbgRdIdx;
  } strobeT;
endpackage

// File: rtl/scpbank_ctrl.sv
module scpbank_ctrl
  import scpbank_pkg::*;
(
  input  logic               xferValid,
  input  logic               xferWrite,
  input  logic [DATA_W-1:0]  xferInstr,
  input  logic [DATA_W-1:0]  xferWdata,
  input  logic               dbgValid,
  input  logic               dbgWrite,
  input  logic [FIELD_W-1:0] dbgIndex,
  input  logic [DATA_W-1:0]  dbgWdata,
  output strobeT             strb
);
  logic [IDX_W-1:0] coreIdx;
  logic             dbgInRange;
  logic             coreWr;
  logic             dbgWr;

  // Only the low bits of the instruction field select an entry.
  assign coreIdx    = xferInstr[FIELD_LSB +: IDX_W];
  assign dbgInRange = (int'(dbgIndex) < NUM_REGS);
  assign coreWr     = xferValid & xferWrite;
  assign dbgWr      = dbgValid & dbgWrite & dbgInRange;

  always_comb begin
    strb           = '0;
    strb.wrEn      = coreWr | dbgWr;
    strb.wrIdx     = coreWr ? coreIdx : dbgIndex[IDX_W-1:0];
    strb.wrData    = coreWr ? xferWdata : dbgWdata;
    strb.coreRd    = xferValid & ~xferWrite;
    strb.coreRdIdx = coreIdx;
    strb.dbgRd     = dbgValid & ~dbgWrite;
    strb.dbgRdOk   = dbgInRange;
    strb.dbgRdIdx  = dbgIndex[IDX_W-1:0];
  end
endmodule

// File: rtl/scpbank_datapath.sv
module scpbank_datapath
  import scpbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  strapCfg,
  input  strobeT            strb,
  output logic [DATA_W-1:0] coreRdata,
  output logic [DATA_W-1:0] dbgRdata,
  output logic [CFG_W-1:0]  cfgOut,
  output logic              reconfigPulse
);
  logic [DATA_W-1:0] regFile [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    if (i == ID_IDX) begin : g_id
      assign regFile[i] = ID_VALUE;
    end else if (i == CTRL_IDX) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rstN)
          regFile[i] <= DATA_W'({strapCfg, {CFG_LSB{1'b0}}});
        else if (strb.wrEn && int'(strb.wrIdx) == i)
          regFile[i] <= strb.wrData;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)
          regFile[i] <= '0;
        else if (strb.wrEn && int'(strb.wrIdx) == i)
          regFile[i] <= strb.wrData;
      end
    end
  end

  assign cfgOut = regFile[CTRL_IDX][CFG_LSB +: CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reconfigPulse <= 1'b0;
      coreRdata     <= '0;
      dbgRdata      <= '0;
    end else begin
      reconfigPulse <= strb.wrEn && (int'(strb.wrIdx) == CTRL_IDX);
      if (strb.coreRd)
        coreRdata <= regFile[strb.coreRdIdx];
      if (strb.dbgRd)
        dbgRdata <= strb.dbgRdOk ? regFile[strb.dbgRdIdx] : '0;
    end
  end

  // R8: a plain entry not targeted by a write keeps its value
  a_r8_plain_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrEn && int'(strb.wrIdx) == 2) |=> $stable(regFile[2]));
endmodule

// File: rtl/scpbank_top.sv
module scpbank_top
  import scpbank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapProgWide,
  input  logic               strapDataWide,
  input  logic               strapLateAbort,
  input  logic               strapBigEnd,
  input  logic               xferValid,
  input  logic               xferWrite,
  input  logic [DATA_W-1:0]  xferInstr,
  input  logic [DATA_W-1:0]  xferWdata,
  output logic [DATA_W-1:0]  xferRdata,
  input  logic               dbgValid,
  input  logic               dbgWrite,
  input  logic [FIELD_W-1:0] dbgIndex,
  input  logic [DATA_W-1:0]  dbgWdata,
  output logic [DATA_W-1:0]  dbgRdata,
  output logic               cfgProgWide,
  output logic               cfgDataWide,
  output logic               cfgLateAbort,
  output logic               cfgBigEnd,
  output logic               reconfigPulse
);
  strobeT           strb;
  logic [CFG_W-1:0] cfgVec;

  scpbank_ctrl u_ctrl (
    .xferValid(xferValid), .xferWrite(xferWrite), .xferInstr(xferInstr),
    .xferWdata(xferWdata), .dbgValid(dbgValid), .dbgWrite(dbgWrite),
    .dbgIndex(dbgIndex), .dbgWdata(dbgWdata), .strb(strb)
  );

  scpbank_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .strapCfg({strapBigEnd, strapLateAbort, strapDataWide, strapProgWide}),
    .strb(strb), .coreRdata(xferRdata), .dbgRdata(dbgRdata),
    .cfgOut(cfgVec), .reconfigPulse(reconfigPulse)
  );

  assign {cfgBigEnd, cfgLateAbort, cfgDataWide, cfgProgWide} = cfgVec;

  // Port-level views used only by the properties below.
  logic coreWrCtrl, dbgWrCtrl, dbgWrOut, coreRdId, coreRdCtrl;
  assign coreWrCtrl = xferValid && xferWrite && int'(xferInstr[FIELD_LSB +: IDX_W]) == CTRL_IDX;
  assign dbgWrCtrl  = dbgValid && dbgWrite && int'(dbgIndex) == CTRL_IDX;
  assign dbgWrOut   = dbgValid && dbgWrite && int'(dbgIndex) >= NUM_REGS;
  assign coreRdId   = xferValid && !xferWrite && int'(xferInstr[FIELD_LSB +: IDX_W]) == ID_IDX;
  assign coreRdCtrl = xferValid && !xferWrite && int'(xferInstr[FIELD_LSB +: IDX_W]) == CTRL_IDX;

  a_r2_id_read: assert property (@(posedge clk) disable iff (!rstN)
    coreRdId |=> xferRdata == ID_VALUE);

  a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rstN)
    coreWrCtrl |=> reconfigPulse);

  a_r4_cfg_steady: assert property (@(posedge clk) disable iff (!rstN)
    !(coreWrCtrl || dbgWrCtrl) |=> $stable(cfgVec));

  a_r7_oob_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrOut && !(xferValid && xferWrite)) |=> !reconfigPulse);

  a_r4_cfg_readback: assert property (@(posedge clk) disable iff (!rstN)
    coreRdCtrl |=> xferRdata[CFG_LSB +: CFG_W] == $past(cfgVec));
endmodule

// File: tb/test_scpbank_top.sv
module test_scpbank_top;
  localparam logic [31:0] IDV = 32'h41440110;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sProg = 1'b0, sData = 1'b1, sLate = 1'b0, sBig = 1'b1;
  logic        xferValid = 1'b0, xferWrite = 1'b0;
  logic [31:0] xferInstr = '0, xferWdata = '0;
  logic [31:0] xferRdata, dbgRdata;
  logic        dbgValid = 1'b0, dbgWrite = 1'b0;
  logic [3:0]  dbgIndex = '0;
  logic [31:0] dbgWdata = '0;
  logic        cProg, cData, cLate, cBig, pulse;

  int errors = 0;
  int checks = 0;
  bit comparing = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scpbank_top i_scpbank_top (
    .clk(clk), .rstN(rstN),
    .strapProgWide(sProg), .strapDataWide(sData),
    .strapLateAbort(sLate), .strapBigEnd(sBig),
    .xferValid(xferValid), .xferWrite(xferWrite), .xferInstr(xferInstr),
    .xferWdata(xferWdata), .xferRdata(xferRdata),
    .dbgValid(dbgValid), .dbgWrite(dbgWrite), .dbgIndex(dbgIndex),
    .dbgWdata(dbgWdata), .dbgRdata(dbgRdata),
    .cfgProgWide(cProg), .cfgDataWide(cData), .cfgLateAbort(cLate),
    .cfgBigEnd(cBig), .reconfigPulse(pulse)
  );

  // Behavioural reference model
  logic [31:0] mReg [8];
  logic [31:0] mCore, mDbg;
  logic        mPulse;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mReg[i] = 32'h0;
      mReg[0] = IDV;
      mReg[1] = {24'h0, sBig, sLate, sData, sProg, 4'h0};
      mCore = 32'h0; mDbg = 32'h0; mPulse = 1'b0;
    end else begin
      int wIdx;
      logic [31:0] wVal;
      wIdx = -1;
      wVal = 32'h0;
      if (xferValid && !xferWrite) mCore = mReg[xferInstr[18:16]];
      if (dbgValid && !dbgWrite) mDbg = (dbgIndex < 8) ? mReg[dbgIndex[2:0]] : 32'h0;
      if (xferValid && xferWrite) begin
        wIdx = int'(xferInstr[18:16]); wVal = xferWdata;
      end else if (dbgValid && dbgWrite && dbgIndex < 8) begin
        wIdx = int'(dbgIndex); wVal = dbgWdata;
      end
      mPulse = (wIdx == 1);
      if (wIdx > 0) mReg[wIdx] = wVal;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (comparing) begin
      check("R3 xferRdata", xferRdata, mCore);
      check("R7 dbgRdata", dbgRdata, mDbg);
      check("R4 cfg outputs", {28'h0, cBig, cLate, cData, cProg}, {28'h0, mReg[1][7:4]});
      check("R5 reconfigPulse", {31'h0, pulse}, {31'h0, mPulse});
    end
  end

  task automatic idle();
    xferValid = 1'b0; xferWrite = 1'b0; dbgValid = 1'b0; dbgWrite = 1'b0;
  endtask

  task automatic coreWr(logic [3:0] f, logic [31:0] v);
    @(negedge clk);
    idle();
    xferValid = 1'b1; xferWrite = 1'b1;
    xferInstr = 32'hEE000F10 | (32'(f) << 16); xferWdata = v;
    @(negedge clk);
    idle();
  endtask

  task automatic coreRd(logic [3:0] f, logic [31:0] exp, string tag);
    @(negedge clk);
    idle();
    xferValid = 1'b1; xferInstr = 32'hEE100F10 | (32'(f) << 16);
    @(negedge clk);
    idle();
    check(tag, xferRdata, exp);
  endtask

  task automatic dbgWr(logic [3:0] idx, logic [31:0] v);
    @(negedge clk);
    idle();
    dbgValid = 1'b1; dbgWrite = 1'b1; dbgIndex = idx; dbgWdata = v;
    @(negedge clk);
    idle();
  endtask

  task automatic dbgRd(logic [3:0] idx, logic [31:0] exp, string tag);
    @(negedge clk);
    idle();
    dbgValid = 1'b1; dbgIndex = idx;
    @(negedge clk);
    idle();
    check(tag, dbgRdata, exp);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    comparing = 1'b1;
    // R1: reset state from straps
    check("R1 cfg reset", {28'h0, cBig, cLate, cData, cProg}, 32'hA);
    check("R1 pulse reset", {31'h0, pulse}, 32'h0);
    check("R1 rdata reset", xferRdata, 32'h0);
    dbgRd(4'd1, 32'h000000A0, "R1 ctrl reset");
    dbgRd(4'd5, 32'h0, "R1 plain reset");
    // R2: fixed ID
    coreRd(4'd0, IDV, "R2 id read");
    coreWr(4'd0, 32'hDEADBEEF);
    coreRd(4'd0, IDV, "R2 id after write");
    dbgWr(4'd0, 32'h12345678);
    dbgRd(4'd0, IDV, "R2 id dbg");
    // R4/R5: control write
    coreWr(4'd1, 32'h00000050);
    check("R4 cfg after write", {28'h0, cBig, cLate, cData, cProg}, 32'h5);
    // R3 masking with bit 19, R6 other bits stored
    coreWr(4'd9, 32'hFFFFFF0F);
    coreRd(4'd1, 32'hFFFFFF0F, "R6 ctrl other bits");
    check("R6 cfg unaffected", {28'h0, cBig, cLate, cData, cProg}, 32'h0);
    coreWr(4'd1, 32'h123456F3);
    dbgRd(4'd1, 32'h123456F3, "R6 ctrl readback");
    // R8: plain storage
    for (int i = 2; i < 8; i++) begin
      if (i[0]) dbgWr(4'(i), 32'hA5000000 + 32'(i));
      else coreWr(4'(i), 32'h5A000000 + 32'(i));
    end
    for (int i = 2; i < 8; i++)
      coreRd(4'(i), i[0] ? 32'hA5000000 + 32'(i) : 32'h5A000000 + 32'(i), "R8 storage");
    // R7: out-of-range debug index
    dbgWr(4'd9, 32'h00000000);
    check("R7 no pulse", {31'h0, pulse}, 32'h0);
    dbgRd(4'd1, 32'h123456F3, "R7 no alias write");
    dbgRd(4'd9, 32'h0, "R7 oob read zero");
    dbgRd(4'd15, 32'h0, "R7 oob read zero 15");
    // R5: debug write to control pulses
    dbgWr(4'd1, 32'h00000080);
    dbgRd(4'd1, 32'h00000080, "R5 dbg ctrl write");
    // R9: simultaneous writes
    @(negedge clk);
    xferValid = 1'b1; xferWrite = 1'b1; xferInstr = 32'h00030000; xferWdata = 32'h11111111;
    dbgValid = 1'b1; dbgWrite = 1'b1; dbgIndex = 4'd3; dbgWdata = 32'h22222222;
    @(negedge clk);
    xferInstr = 32'h00040000; xferWdata = 32'h33333333;
    dbgIndex = 4'd5; dbgWdata = 32'h44444444;
    @(negedge clk);
    idle();
    dbgRd(4'd3, 32'h11111111, "R9 core wins same entry");
    dbgRd(4'd5, 32'hA5000005, "R9 debug dropped");
    // R5: back-to-back control writes
    @(negedge clk);
    xferValid = 1'b1; xferWrite = 1'b1; xferInstr = 32'h00010000; xferWdata = 32'h10;
    @(negedge clk);
    xferWdata = 32'h20;
    check("R5 first pulse", {31'h0, pulse}, 32'h1);
    @(negedge clk);
    idle();
    check("R5 second pulse", {31'h0, pulse}, 32'h1);
    @(negedge clk);
    check("R5 pulse ends", {31'h0, pulse}, 32'h0);
    check("R4 final cfg", {28'h0, cBig, cLate, cData, cProg}, 32'h2);
    repeat (2) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule